// File: doc/BRIEF.md
# Successive-Approximation Sequencer

This block runs the digital side of a successive-approximation converter. It performs a binary search over a WIDTH-bit code, one bit per clock, starting from the most significant bit. The code goes straight to an external DAC. A single comparator bit comes back and tells the block whether the DAC level is at or below the held input. The sample-and-hold, the DAC and the comparator sit outside the block.

Sequencing uses no counter. A one-hot token moves through a chain of stages, one stage per clock. When the token enters the stage for a bit, that bit is set to 1 as a trial. When the token leaves the stage, the bit is overwritten with the comparator decision. A sticky final stage raises `done`.

Every storage element is the same cell: clear has priority over set, and set has priority over a data load. All logic runs on one clock edge, and no clock is derived from the token.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After `rst` is high for a clock edge, `code` is 0 and `done` is 0. Both stay that way on later edges until `sample` is raised.
- R2: On any edge where `sample` is high, `code` is cleared to 0 and `done` to 0. This includes an edge in the middle of a conversion, which abandons that conversion.
- R3: Bits resolve strictly from MSB to LSB, one per clock. After the k-th edge following the fall of `sample` (1 ≤ k ≤ WIDTH), the trial position is bit WIDTH-k, and every bit below it reads 0.
- R4: On the edge where the token reaches a bit position, that bit of `code` becomes 1 (the trial value seen by the DAC).
- R5: On the edge where the token leaves a bit position, that bit takes the value of `comp_hi` just before the edge. `comp_hi` = 1 means the DAC level is at or below the input, and the bit stays 1. With an ideal comparator the final code equals the input code.
- R6: `done` rises on edge WIDTH+1 after the fall of `sample`, and is 0 on every edge before it.
- R7: While `done` is high and `sample` is low, `done` stays high and `code` does not change, whatever `comp_hi` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sample | input | 1 | High during acquisition; clears the result and re-arms the token |
| comp_hi | input | 1 | Comparator decision: 1 when the DAC level is not above the input |
| code | output | WIDTH | Trial/result code driving the DAC |
| done | output | 1 | High from the end of a conversion until the next sample |

## Verification
The bench builds the block with the default WIDTH of 12 and closes the loop through an ideal DAC and comparator driven by an integer input code. At this width the bench can reach the all-zeros, all-ones and mid-scale codes exactly, as well as codes on either side of mid-scale. Its per-edge checks can therefore watch the trial bit walk across all twelve positions and confirm that `done` arrives on the thirteenth edge.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    // Default resolution of the successive-approximation search.
    localparam int SAR_DEF_BITS = 12;

    // Control bundle of one storage cell: clear beats set, set beats load.
    typedef struct packed {
        logic clr;
        logic set;
        logic load;
        logic d;
    } srd_ctrl_t;

    function automatic srd_ctrl_t srd_make(input logic clr, input logic set,
                                           input logic load, input logic d);
        srd_ctrl_t c;
        c.clr  = clr;
        c.set  = set;
        c.load = load;
        c.d    = d;
        return c;
    endfunction

endpackage

// File: rtl/sar_srd_cell.sv
module sar_srd_cell
    import sar_seq_pkg::*;
(
    input  logic      clk,
    input  srd_ctrl_t ctl,
    output logic      q
);
    always_ff @(posedge clk) begin
        if (ctl.clr)
            q <= 1'b0;
        else if (ctl.set)
            q <= 1'b1;
        else if (ctl.load)
            q <= ctl.d;
    end
endmodule

// File: rtl/sar_token_chain.sv
module sar_token_chain
    import sar_seq_pkg::*;
#(
    parameter int WIDTH = SAR_DEF_BITS
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sample,
    output logic [WIDTH:0] tok,
    output logic           done
);
    // tok[WIDTH] is the start stage; tok[i] for i < WIDTH belongs to bit i.
    sar_srd_cell u_start (
        .clk (clk),
        .ctl (srd_make(rst, sample, 1'b1, 1'b0)),
        .q   (tok[WIDTH])
    );

    for (genvar g = 0; g < WIDTH; g++) begin : g_stage
        sar_srd_cell u_stage (
            .clk (clk),
            .ctl (srd_make(rst | sample, 1'b0, 1'b1, tok[g+1])),
            .q   (tok[g])
        );
    end

    // Final stage is sticky: set by the LSB stage, cleared only by sample.
    sar_srd_cell u_done (
        .clk (clk),
        .ctl (srd_make(rst | sample, tok[0], 1'b0, 1'b0)),
        .q   (done)
    );

    AST_TOKEN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tok)); // R3

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (done && !sample) |=> done); // R7
endmodule

// File: rtl/sar_result_row.sv
module sar_result_row
    import sar_seq_pkg::*;
#(
    parameter int WIDTH = SAR_DEF_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample,
    input  logic             comp_hi,
    input  logic [WIDTH:0]   tok,
    output logic [WIDTH-1:0] code
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        // Token arriving (tok[g+1]) sets the trial; token leaving (tok[g]) loads the decision.
        sar_srd_cell u_bit (
            .clk (clk),
            .ctl (srd_make(rst | sample, tok[g+1], tok[g], comp_hi)),
            .q   (code[g])
        );

        AST_TRIAL_BIT: assert property (@(posedge clk) disable iff (rst)
            tok[g] |-> code[g]); // R4

        AST_DECISION_BIT: assert property (@(posedge clk) disable iff (rst)
            (tok[g] && !sample) |=> (code[g] == $past(comp_hi))); // R5
    end

    AST_SAMPLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        sample |=> (code == '0)); // R2
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int WIDTH = SAR_DEF_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample,
    input  logic             comp_hi,
    output logic [WIDTH-1:0] code,
    output logic             done
);
    localparam int STAGES = WIDTH + 1;

    logic [STAGES-1:0] tok;

    sar_token_chain #(.WIDTH(WIDTH)) u_chain (
        .clk    (clk),
        .rst    (rst),
        .sample (sample),
        .tok    (tok),
        .done   (done)
    );

    sar_result_row #(.WIDTH(WIDTH)) u_row (
        .clk     (clk),
        .rst     (rst),
        .sample  (sample),
        .comp_hi (comp_hi),
        .tok     (tok),
        .code    (code)
    );

    AST_DONE_FREEZES_CODE: assert property (@(posedge clk) disable iff (rst)
        (done && !sample) |=> $stable(code)); // R7

    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        sample |=> !done); // R2
endmodule

// File: tb/sar_seq_ctrl_bench.sv
module sar_seq_ctrl_bench;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sample = 1'b0;
    logic         comp_hi;
    logic [W-1:0] code;
    logic         done;
    int           vin = 0;
    int           n_run = 0;
    int           n_fail = 0;
    int           cyc = 0;

    always #10 clk = ~clk;

    // Ideal DAC plus comparator: high when the DAC level is not above the input.
    assign comp_hi = (int'(code) <= vin);

    sar_seq_ctrl #(.WIDTH(W)) u_sar_seq_ctrl (
        .clk (clk), .rst (rst), .sample (sample), .comp_hi (comp_hi),
        .code (code), .done (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            chk(1'b0, "WDOG", "watchdog expired", cyc, 100000);
            finish_run();
        end
    end

    task automatic start_sample();
        @(negedge clk) sample = 1'b1;
        @(negedge clk);
        chk(code == '0, "R2", "code during sample", int'(code), 0);
        chk(done == 1'b0, "R2", "done during sample", int'(done), 0);
        sample = 1'b0;
    endtask

    // Runs k edges after the fall of sample and checks each step.
    task automatic step_conv(input int from_k, input int to_k);
        for (int k = from_k; k <= to_k; k++) begin
            @(negedge clk);
            if (k <= W) begin
                chk(code[W-k] == 1'b1, "R4", "trial bit", int'(code[W-k]), 1);
                chk((int'(code) & ((1 << (W-k)) - 1)) == 0, "R3",
                    "bits below trial", int'(code) & ((1 << (W-k)) - 1), 0);
                if (k >= 2)
                    chk((int'(code) >> (W-k+1)) == (vin >> (W-k+1)), "R5",
                        "decided bits", int'(code) >> (W-k+1), vin >> (W-k+1));
                chk(done == 1'b0, "R6", "done early", int'(done), 0);
            end else begin
                chk(done == 1'b1, "R6", "done at end", int'(done), 1);
                chk(int'(code) == vin, "R5", "final code", int'(code), vin);
            end
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(code == '0, "R1", "code after reset", int'(code), 0);
        chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
        repeat (6) @(negedge clk);
        chk(code == '0 && done == 1'b0, "R1", "idle without sample",
            int'(code), 0);
    endtask

    task automatic t_convert(input int v);
        vin = v;
        start_sample();
        step_conv(1, W + 1);
    endtask

    task automatic t_hold_after_done();
        int kept;
        kept = vin;
        vin = (~kept) & ((1 << W) - 1);
        repeat (8) @(negedge clk);
        chk(int'(code) == kept, "R7", "code frozen after done", int'(code), kept);
        chk(done == 1'b1, "R7", "done held", int'(done), 1);
        vin = kept;
    endtask

    task automatic t_restart(input int a, input int b);
        vin = a;
        start_sample();
        step_conv(1, 5);
        start_sample();
        vin = b;
        step_conv(1, W + 1);
    endtask

    initial begin
        t_reset();
        t_convert(0);
        t_convert(4095);
        t_hold_after_done();
        t_convert(2048);
        t_convert(2047);
        t_hold_after_done();
        t_restart(3000, 1234);
        for (int i = 0; i < 6; i++) t_convert(int'($urandom_range(0, 4095)));
        t_convert(1);
        finish_run();
    end
endmodule